// File: doc/BRIEF.md
# Oversampling Serial Receiver with Receive Queue

This block turns an asynchronous serial line into a stream of characters. An external clock-enable pulses eight times per bit period. The receiver uses it to find the start bit, to sample each data bit near the centre of its bit time, and to check the parity and stop bits. Each finished character is stored in a small show-ahead queue together with one error tag. That tag covers a parity mismatch, a bad stop bit and a break, without saying which one occurred.

The input can come from the external pin or, in loopback mode, from the local transmit line. A character that arrives while the queue is full is dropped, and a one-cycle overrun pulse reports the loss. When flow control is on, a request-to-send style output drops as the queue nears full and comes back once it has drained, with a gap between the two thresholds. The host reads characters by pulsing a pop strobe.

Top module: `serial_rx_core`

## Requirements
- R1: The line is sampled only on `tick_8x` cycles. A low level seen in idle starts a candidate start bit. The start bit is accepted only if the line is still low on the fourth tick after that. Otherwise the receiver returns to idle and stores nothing, so a low pulse of two ticks yields no character.
- R2: `cfg_bits` selects the word length: 0 = 5, 1 = 6, 2 = 7, 3 = 8 data bits. Data arrives least-significant bit first and is sampled once per eight ticks. `rd_data` bits above the word length read as zero.
- R3: `cfg_par` selects the parity mode: 0 = none, 1 = odd, 2 = even, 3 = mark (bit must be 1), 4 = space (bit must be 0). For modes 1 to 4 one parity bit follows the data. A mismatch sets the character's error tag and the data is still stored.
- R4: Only the first stop bit is examined. If it is low, the error tag is set. Frames sent with two stop bits are received the same way as frames with one.
- R5: A break (line low through the whole frame) stores exactly one character with data 0 and the error tag set. The receiver then stays inactive until the line returns high.
- R6: The queue holds 16 characters in arrival order. `rd_data`/`rd_err` show the oldest entry while `rd_empty` is 0. `rd_pop` removes it, and `rd_level` gives the count.
- R7: A character completed while the queue holds 16 entries is discarded. `ovr_pulse` is high for one cycle and the stored contents are unchanged.
- R8: With `loop_en` = 1 the receiver takes `loop_tx` and ignores `rx_pin`. With `loop_en` = 0 it takes `rx_pin`.
- R9: With `flow_en` = 1, `rts_ok` goes low once the level is 14 or more. It returns high only when the level is below 12; at 12 and 13 it keeps its value. With `flow_en` = 0, `rts_ok` is high.
- R10: After reset the queue is empty, `rd_level` is 0, `rts_ok` is 1 and `ovr_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_8x | input | 1 | Sampling enable, eight pulses per bit period |
| rx_pin | input | 1 | External serial input, idle high |
| loop_en | input | 1 | Select `loop_tx` as the serial source |
| loop_tx | input | 1 | Local transmitter output used in loopback |
| cfg_bits | input | 2 | Word length code |
| cfg_par | input | 3 | Parity mode code |
| flow_en | input | 1 | Enable flow-control output |
| rd_pop | input | 1 | Remove the oldest queued character |
| rd_data | output | 8 | Oldest queued character |
| rd_err | output | 1 | Error tag of the oldest character |
| rd_empty | output | 1 | Queue holds no character |
| rd_level | output | 5 | Number of queued characters |
| ovr_pulse | output | 1 | One-cycle pulse when a character is lost |
| rts_ok | output | 1 | High when the sender may continue |

## Verification
The hardest state to reach is a queue that sits at its limit while another character is still arriving. Reaching it takes seventeen complete frames with no reads, and the flow-control output has to be checked at each threshold crossing on the way. The bench fills the queue frame by frame and checks `rts_ok` at levels 13 and 14 before forcing the overrun. It then drains the queue one entry at a time and confirms the hold band at 12 and the return at 11. The break and start-glitch cases need the line held low for a time that does not match any frame length, and the bench drives those waveforms directly.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        PAR_NONE  = 3'd0,
        PAR_ODD   = 3'd1,
        PAR_EVEN  = 3'd2,
        PAR_MARK  = 3'd3,
        PAR_SPACE = 3'd4
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_HOLD
    } rx_state_e;

    typedef struct packed {
        logic              err;
        logic [CHAR_W-1:0] data;
    } rx_char_t;

    function automatic logic [3:0] word_len(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

    function automatic logic has_parity(input logic [2:0] mode);
        return (mode == PAR_ODD) || (mode == PAR_EVEN) ||
               (mode == PAR_MARK) || (mode == PAR_SPACE);
    endfunction

    function automatic logic parity_expect(input logic [2:0] mode,
                                           input logic [CHAR_W-1:0] d);
        case (mode)
            PAR_ODD:  return ~(^d);
            PAR_EVEN: return ^d;
            PAR_MARK: return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/rx_frame.sv
module rx_frame
    import serial_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       line,
    input  logic [1:0] cfg_bits,
    input  logic [2:0] cfg_par,
    output logic       char_valid,
    output rx_char_t   char_out
);

    rx_state_e         state;
    logic [2:0]        ph;
    logic [3:0]        bitcnt;
    logic [CHAR_W-1:0] sr;
    logic              par_bit;
    logic [3:0]        len;
    logic [CHAR_W-1:0] aligned;
    logic              par_on;

    always_comb begin
        len     = word_len(cfg_bits);
        aligned = sr >> (4'd8 - len);
        par_on  = has_parity(cfg_par);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            ph         <= '0;
            bitcnt     <= '0;
            sr         <= '0;
            par_bit    <= 1'b0;
            char_valid <= 1'b0;
            char_out   <= '0;
        end else begin
            char_valid <= 1'b0;
            if (tick) begin
                case (state)
                    ST_IDLE: begin
                        if (!line) begin
                            state <= ST_START;
                            ph    <= '0;
                        end
                    end
                    ST_START: begin
                        if (ph == 3'd3) begin
                            ph     <= '0;
                            bitcnt <= '0;
                            state  <= line ? ST_IDLE : ST_DATA;
                        end else begin
                            ph <= ph + 3'd1;
                        end
                    end
                    ST_DATA: begin
                        if (ph == 3'd7) begin
                            ph     <= '0;
                            sr     <= {line, sr[CHAR_W-1:1]};
                            bitcnt <= bitcnt + 4'd1;
                            if (bitcnt == len - 4'd1)
                                state <= par_on ? ST_PAR : ST_STOP;
                        end else begin
                            ph <= ph + 3'd1;
                        end
                    end
                    ST_PAR: begin
                        if (ph == 3'd7) begin
                            ph      <= '0;
                            par_bit <= line;
                            state   <= ST_STOP;
                        end else begin
                            ph <= ph + 3'd1;
                        end
                    end
                    ST_STOP: begin
                        if (ph == 3'd7) begin
                            ph            <= '0;
                            char_valid    <= 1'b1;
                            char_out.data <= aligned;
                            char_out.err  <= (par_on && (par_bit != parity_expect(cfg_par, aligned)))
                                             || !line;
                            state         <= line ? ST_IDLE : ST_HOLD;
                        end else begin
                            ph <= ph + 3'd1;
                        end
                    end
                    default: begin
                        if (line)
                            state <= ST_IDLE;
                    end
                endcase
            end
        end
    end

    // R5: a character is produced only as the stop bit is sampled
    a_r5_valid_from_stop: assert property (@(posedge clk) disable iff (rst)
        char_valid |-> $past(state) == ST_STOP);

    // R1: data phase is entered only if the line was low at start confirmation
    a_r1_start_confirmed_low: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && $past(state) == ST_START) |-> $past(!line));

endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
    import serial_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  rx_char_t      wdata,
    input  logic          pop,
    output rx_char_t      head,
    output logic          empty,
    output logic [LW-1:0] level,
    output logic          ovr
);

    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    rx_char_t      mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    always_comb begin
        do_push = push && (level != FULL_LVL);
        do_pop  = pop && (level != '0);
        empty   = (level == '0);
        head    = mem[rptr];
    end

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
            ovr   <= 1'b0;
        end else begin
            ovr <= push && (level == FULL_LVL);
            if (do_push)
                wptr <= (wptr == LAST_PTR) ? '0 : wptr + 1'b1;
            if (do_pop)
                rptr <= (rptr == LAST_PTR) ? '0 : rptr + 1'b1;
            level <= level + LW'(do_push) - LW'(do_pop);
        end
    end

    // R7: a full queue without a read keeps its level
    a_r7_full_holds: assert property (@(posedge clk) disable iff (rst)
        (level == FULL_LVL && !pop) |=> level == FULL_LVL);

    // R7: loss is reported only when the queue was full
    a_r7_ovr_only_full: assert property (@(posedge clk) disable iff (rst)
        ovr |-> $past(level) == FULL_LVL);

    // R6: level never passes the depth
    a_r6_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= FULL_LVL);

    // R6: reading an empty queue without a write leaves it empty
    a_r6_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (level == '0 && !push) |=> level == '0);

endmodule

// File: rtl/rx_flow.sv
module rx_flow #(
    parameter int LW     = 5,
    parameter int OFF_AT = 14,
    parameter int ON_LT  = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flow_en,
    input  logic [LW-1:0] level,
    output logic          rts_ok
);

    localparam logic [LW-1:0] OFF_LVL = LW'(OFF_AT);
    localparam logic [LW-1:0] ON_LVL  = LW'(ON_LT);

    always_ff @(posedge clk) begin
        if (rst)
            rts_ok <= 1'b1;
        else if (!flow_en)
            rts_ok <= 1'b1;
        else if (level >= OFF_LVL)
            rts_ok <= 1'b0;
        else if (level < ON_LVL)
            rts_ok <= 1'b1;
    end

    // R9: the output drops only under flow control with a high level
    a_r9_fall_high: assert property (@(posedge clk) disable iff (rst)
        $fell(rts_ok) |-> ($past(flow_en) && $past(level) >= OFF_LVL));

    // R9: under flow control the output rises only with a low level
    a_r9_rise_low: assert property (@(posedge clk) disable iff (rst)
        ($rose(rts_ok) && $past(flow_en)) |-> $past(level) < ON_LVL);

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import serial_rx_pkg::*;
#(
    parameter int FIFO_DEPTH   = 16,
    parameter int RTS_OFF_AT   = 14,
    parameter int RTS_ON_BELOW = 12,
    localparam int LW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_8x,
    input  logic          rx_pin,
    input  logic          loop_en,
    input  logic          loop_tx,
    input  logic [1:0]    cfg_bits,
    input  logic [2:0]    cfg_par,
    input  logic          flow_en,
    input  logic          rd_pop,
    output logic [7:0]    rd_data,
    output logic          rd_err,
    output logic          rd_empty,
    output logic [LW-1:0] rd_level,
    output logic          ovr_pulse,
    output logic          rts_ok
);

    logic [1:0] sync_q;
    logic       char_valid;
    rx_char_t   char_new;
    rx_char_t   head;

    always_ff @(posedge clk) begin
        if (rst)
            sync_q <= 2'b11;
        else
            sync_q <= {sync_q[0], loop_en ? loop_tx : rx_pin};
    end

    rx_frame u_frame (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick_8x),
        .line       (sync_q[1]),
        .cfg_bits   (cfg_bits),
        .cfg_par    (cfg_par),
        .char_valid (char_valid),
        .char_out   (char_new)
    );

    rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (char_valid),
        .wdata (char_new),
        .pop   (rd_pop),
        .head  (head),
        .empty (rd_empty),
        .level (rd_level),
        .ovr   (ovr_pulse)
    );

    rx_flow #(.LW(LW), .OFF_AT(RTS_OFF_AT), .ON_LT(RTS_ON_BELOW)) u_flow (
        .clk     (clk),
        .rst     (rst),
        .flow_en (flow_en),
        .level   (rd_level),
        .rts_ok  (rts_ok)
    );

    always_comb begin
        rd_data = head.data;
        rd_err  = head.err;
    end

endmodule

// File: tb/serial_rx_core_bench.sv
module serial_rx_core_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_8x = 1'b0;
    logic       rx_pin = 1'b1;
    logic       loop_en = 1'b0;
    logic       loop_tx = 1'b1;
    logic [1:0] cfg_bits = 2'd3;
    logic [2:0] cfg_par = 3'd0;
    logic       flow_en = 1'b0;
    logic       rd_pop = 1'b0;
    logic [7:0] rd_data;
    logic       rd_err;
    logic       rd_empty;
    logic [4:0] rd_level;
    logic       ovr_pulse;
    logic       rts_ok;

    int checks = 0;
    int failures = 0;
    int ovr_seen = 0;
    int tc = 0;
    bit done = 0;
    logic [8:0] exp_q[$];

    localparam int BIT_CLKS = 32;

    always #4 clk = ~clk;

    serial_rx_core u_serial_rx_core (
        .clk(clk), .rst(rst), .tick_8x(tick_8x), .rx_pin(rx_pin),
        .loop_en(loop_en), .loop_tx(loop_tx), .cfg_bits(cfg_bits),
        .cfg_par(cfg_par), .flow_en(flow_en), .rd_pop(rd_pop),
        .rd_data(rd_data), .rd_err(rd_err), .rd_empty(rd_empty),
        .rd_level(rd_level), .ovr_pulse(ovr_pulse), .rts_ok(rts_ok)
    );

    always @(negedge clk) begin
        tick_8x <= (tc == 3);
        tc = (tc + 1) % 4;
        if (!rst && ovr_pulse) ovr_seen++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic drive(input bit to_loop, input bit v, input int clks);
        if (to_loop) loop_tx = v; else rx_pin = v;
        wait_clks(clks);
    endtask

    // builds one frame; model enqueues expected result or expects a loss
    task automatic send(input logic [7:0] d, input int nbits, input int pmode,
                        input bit flip, input bit stop1, input int nstops,
                        input bit to_loop, input bit counts);
        int ones = 0;
        bit pbit;
        logic [7:0] m;
        m = d & 8'((1 << nbits) - 1);
        for (int i = 0; i < nbits; i++) ones += m[i];
        case (pmode)
            1: pbit = (ones % 2 == 0);
            2: pbit = (ones % 2 == 1);
            3: pbit = 1'b1;
            default: pbit = 1'b0;
        endcase
        if (flip) pbit = ~pbit;
        drive(to_loop, 1'b0, BIT_CLKS);
        for (int i = 0; i < nbits; i++) drive(to_loop, m[i], BIT_CLKS);
        if (pmode != 0) drive(to_loop, pbit, BIT_CLKS);
        drive(to_loop, stop1, BIT_CLKS);
        if (nstops == 2) drive(to_loop, 1'b1, BIT_CLKS);
        drive(to_loop, 1'b1, BIT_CLKS);
        if (counts) begin
            if (exp_q.size() < 16)
                exp_q.push_back({((pmode != 0) && flip) || !stop1, m});
        end
    endtask

    task automatic pop_check(input string req);
        logic [8:0] e;
        if (exp_q.size() == 0) begin
            chk(rd_empty, req, rd_empty, 1);
            return;
        end
        e = exp_q.pop_front();
        chk(!rd_empty, req, rd_empty, 0);
        chk(rd_data == e[7:0], req, rd_data, e[7:0]);
        chk(rd_err == e[8], req, rd_err, e[8]);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        @(negedge clk);
        chk(rd_level == 5'(exp_q.size()), req, rd_level, exp_q.size());
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        wait_clks(5);
        // R10 reset state
        chk(rd_empty == 1, "R10", rd_empty, 1);
        chk(rd_level == 0, "R10", rd_level, 0);
        chk(rts_ok == 1, "R10", rts_ok, 1);
        chk(ovr_pulse == 0, "R10", ovr_pulse, 0);
        rst = 1'b0;
        wait_clks(20);

        // R2 word lengths
        cfg_bits = 2'd3; cfg_par = 3'd0;
        send(8'hA5, 8, 0, 0, 1, 1, 0, 1); pop_check("R2 8 bits");
        cfg_bits = 2'd0;
        send(8'hF5, 5, 0, 0, 1, 1, 0, 1); pop_check("R2 5 bits");
        cfg_bits = 2'd1;
        send(8'h2C, 6, 0, 0, 1, 1, 0, 1); pop_check("R2 6 bits");

        // R3 parity modes
        cfg_bits = 2'd1; cfg_par = 3'd1;
        send(8'h2C, 6, 1, 0, 1, 1, 0, 1); pop_check("R3 odd");
        cfg_bits = 2'd2; cfg_par = 3'd2;
        send(8'h5B, 7, 2, 0, 1, 1, 0, 1); pop_check("R3 even");
        send(8'h5B, 7, 2, 1, 1, 1, 0, 1); pop_check("R3 even bad");
        cfg_bits = 2'd3; cfg_par = 3'd3;
        send(8'h3C, 8, 3, 0, 1, 1, 0, 1); pop_check("R3 mark");
        send(8'h3C, 8, 3, 1, 1, 1, 0, 1); pop_check("R3 mark bad");
        cfg_par = 3'd4;
        send(8'hC3, 8, 4, 0, 1, 1, 0, 1); pop_check("R3 space");
        send(8'hC3, 8, 4, 1, 1, 1, 0, 1); pop_check("R3 space bad");

        // R4 stop bits
        cfg_par = 3'd0;
        send(8'h81, 8, 0, 0, 0, 1, 0, 1); pop_check("R4 bad stop");
        send(8'h42, 8, 0, 0, 0, 2, 0, 1); pop_check("R4 bad first of two");
        send(8'h66, 8, 0, 0, 1, 2, 0, 1);
        send(8'h99, 8, 0, 0, 1, 2, 0, 1);
        pop_check("R4 two stops a"); pop_check("R4 two stops b");

        // R1 short low pulse ignored
        drive(0, 1'b0, 8);
        drive(0, 1'b1, 4 * BIT_CLKS);
        chk(rd_level == 0, "R1 glitch", rd_level, 0);
        chk(rd_empty == 1, "R1 glitch", rd_empty, 1);

        // R5 break
        drive(0, 1'b0, 14 * BIT_CLKS);
        chk(rd_level == 1, "R5 break single", rd_level, 1);
        drive(0, 1'b1, 3 * BIT_CLKS);
        chk(rd_level == 1, "R5 break single", rd_level, 1);
        exp_q.push_back(9'h100);
        pop_check("R5 break value");

        // R8 loopback
        loop_en = 1'b1;
        send(8'h5E, 8, 0, 0, 1, 1, 1, 1); pop_check("R8 loop source");
        send(8'h11, 8, 0, 0, 1, 1, 0, 0);
        chk(rd_level == 0, "R8 pin ignored", rd_level, 0);
        loop_en = 1'b0;
        send(8'h77, 8, 0, 0, 1, 1, 0, 1); pop_check("R8 pin source");

        // R6, R7, R9 fill
        flow_en = 1'b1;
        for (int k = 0; k < 13; k++) send(8'(k + 8'h30), 8, 0, 0, 1, 1, 0, 1);
        chk(rd_level == 13, "R6 level", rd_level, 13);
        chk(rts_ok == 1, "R9 at 13", rts_ok, 1);
        send(8'h3D, 8, 0, 0, 1, 1, 0, 1);
        chk(rts_ok == 0, "R9 at 14", rts_ok, 0);
        send(8'h3E, 8, 0, 0, 1, 1, 0, 1);
        send(8'h3F, 8, 0, 0, 1, 1, 0, 1);
        chk(rd_level == 16, "R6 full", rd_level, 16);
        chk(ovr_seen == 0, "R7 no loss yet", ovr_seen, 0);
        send(8'hEE, 8, 0, 0, 1, 1, 0, 1);
        chk(ovr_seen == 1, "R7 overrun pulse", ovr_seen, 1);
        chk(rd_level == 16, "R7 level kept", rd_level, 16);
        flow_en = 1'b0; wait_clks(3);
        chk(rts_ok == 1, "R9 disabled", rts_ok, 1);
        flow_en = 1'b1; wait_clks(3);
        chk(rts_ok == 0, "R9 reenabled", rts_ok, 0);
        for (int k = 0; k < 4; k++) pop_check("R6 order");
        wait_clks(2);
        chk(rts_ok == 0, "R9 hold at 12", rts_ok, 0);
        pop_check("R6 order");
        wait_clks(2);
        chk(rts_ok == 1, "R9 back below 12", rts_ok, 1);
        while (exp_q.size() > 0) pop_check("R7 contents intact");
        chk(rd_empty == 1, "R6 drained", rd_empty, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule